// File: doc/BRIEF.md
# Dual-Issue Pair Steering

This block sits at the front of a two-wide in-order pipeline. Each cycle fetch offers one 64-bit packet that holds two 32-bit instructions. The lower half holds an integer-class instruction, and that class includes integer loads and stores, floating-point loads and stores, and branches. The upper half holds a floating-point arithmetic operation. Packets are aligned and the two slots are never swapped. The block decodes both slots and checks that each slot holds the type it should. It compares all six register specifiers against each other and against a scoreboard of writes still in flight. It then decides whether no instruction, the lower one only, the upper one only, or both go out this cycle.

Each issued instruction leaves on the port that matches its type. Floating-point operations use the FP port and every other class uses the integer port. The block raises `advance` when the whole packet has been consumed, and fetch holds the packet until then. An upper slot that was left behind is issued alone in the next cycle with the packet still held. Floating-point loads and stores compute their address in the integer pipe but move an FP register, so their hazard checks reach into both register classes. The FP pipe has a longer latency than the integer pipe and results complete out of order. For that reason both RAW and WAW hazards against pending writes stall issue.

Instruction fields: class in bits 31:28, destination in 27:23, first source in 22:18, second source in 17:13. A register specifier selects register `field mod NREG`. Class codes: 0 integer ALU (rd, rs1, rs2 integer), 1 integer load (rd, rs1 integer), 2 integer store (rs1, rs2 integer), 3 FP load (rd FP, rs1 integer), 4 FP store (rs1 integer, rs2 FP), 5 branch (rs1, rs2 integer), 6 FP operation (rd, rs1, rs2 FP). Codes 7 to 15 are integer-class instructions that use no registers.

Top module: `pair_issue_steer`

## Requirements
- R1: With an integer-class instruction in the lower slot, an FP operation (class 6) in the upper slot and no hazard, both issue in the same cycle. The lower one goes on the integer port and the upper one on the FP port, and `issue_fp_ins` only ever carries class 6.
- R2: The upper slot never issues in a cycle in which the lower slot is valid, not yet issued, and does not issue.
- R3: If the lower slot holds class 6 or the upper slot holds anything other than class 6, only the lower slot issues. The upper slot issues alone in a later cycle, on the port its class selects. The integer port never carries class 6.
- R4: If the lower slot is an FP load and the upper FP operation reads the load's destination, or writes the same FP register, only the load issues that cycle.
- R5: An instruction whose source register (integer or FP, according to its class) has a pending write does not issue.
- R6: An instruction whose destination register has a pending write does not issue.
- R7: Issuing an instruction with a destination marks that register pending from the next cycle. A writeback clears the mark from the next cycle, with no bypass in the writeback cycle. A mark set in the same cycle as a clear of the same register wins.
- R8: Integer register 0 is never pending, whether written or read.
- R9: `advance` is high exactly when every valid slot of the packet has issued, now or in an earlier cycle of the same packet. A packet with no valid slot advances at once. An upper slot whose lower slot is invalid is treated as issuing alone.
- R10: After reset no register is pending and no upper-slot replay is outstanding. With no valid slot, both issue strobes are low.
- R11: An FP load checks its integer base and its FP destination. An FP store checks its integer base and its FP data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_vld | input | 2 | Slot valid bits, bit 0 lower, bit 1 upper |
| pkt | input | 64 | Fetch packet, lower instruction in bits 31:0 |
| wb_int_en | input | 1 | Integer writeback strobe |
| wb_int_idx | input | RW | Integer register written back |
| wb_fp_en | input | 1 | FP writeback strobe |
| wb_fp_idx | input | RW | FP register written back |
| issue_int | output | 1 | Integer port issues this cycle |
| issue_int_ins | output | 32 | Instruction on the integer port |
| issue_fp | output | 1 | FP port issues this cycle |
| issue_fp_ins | output | 32 | Instruction on the FP port |
| advance | output | 1 | Packet fully consumed, fetch may move on |

## Verification
The bench builds the block with NREG = 8, so each register file has eight entries and RW = 3. Randomly drawn 5-bit specifiers then collide often. That makes it routine to hit intra-pair load-to-operation conflicts, stalls on pending sources and destinations, and writebacks landing on the same register in the same cycle that it stalls or is set again. Those cases would be rare with 32 registers. The narrow index also exercises the modulo mapping of the 5-bit fields.

// File: rtl/pst_pkg.sv
// Shared types for the pair steering block.
// Assumes the fixed field layout: class 31:28, rd 27:23, rs1 22:18, rs2 17:13.
package pst_pkg;

    localparam int INS_W = 32;
    localparam int FLD_W = 5;
    localparam int HDR_LO = 13;
    localparam int HDR_W = INS_W - HDR_LO;

    localparam logic [3:0] OC_ALU = 4'd0;
    localparam logic [3:0] OC_LD  = 4'd1;
    localparam logic [3:0] OC_ST  = 4'd2;
    localparam logic [3:0] OC_FLD = 4'd3;
    localparam logic [3:0] OC_FST = 4'd4;
    localparam logic [3:0] OC_BR  = 4'd5;
    localparam logic [3:0] OC_FOP = 4'd6;

    // Register usage of one slot after decode.
    typedef struct packed {
        logic             is_fop;
        logic             is_fld;
        logic             use1;
        logic             src1_fp;
        logic             use2;
        logic             src2_fp;
        logic             wr;
        logic             wr_fp;
        logic [FLD_W-1:0] rd;
        logic [FLD_W-1:0] rs1;
        logic [FLD_W-1:0] rs2;
    } dec_t;

endpackage

// File: rtl/pst_decode.sv
// Slot decoder: turns the class and register fields of one instruction
// into register-usage flags. Pure combinational; unknown classes use no registers.
module pst_decode
    import pst_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output dec_t             dec
);

    // Map the class code to source/destination usage and register file.
    always_comb begin
        dec     = '0;
        dec.rd  = hdr[27-HDR_LO -: FLD_W];
        dec.rs1 = hdr[22-HDR_LO -: FLD_W];
        dec.rs2 = hdr[17-HDR_LO -: FLD_W];
        case (hdr[HDR_W-1 -: 4])
            OC_ALU: begin
                dec.use1 = 1'b1;
                dec.use2 = 1'b1;
                dec.wr   = 1'b1;
            end
            OC_LD: begin
                dec.use1 = 1'b1;
                dec.wr   = 1'b1;
            end
            OC_ST, OC_BR: begin
                dec.use1 = 1'b1;
                dec.use2 = 1'b1;
            end
            OC_FLD: begin
                dec.use1   = 1'b1;
                dec.wr     = 1'b1;
                dec.wr_fp  = 1'b1;
                dec.is_fld = 1'b1;
            end
            OC_FST: begin
                dec.use1    = 1'b1;
                dec.use2    = 1'b1;
                dec.src2_fp = 1'b1;
            end
            OC_FOP: begin
                dec.use1    = 1'b1;
                dec.src1_fp = 1'b1;
                dec.use2    = 1'b1;
                dec.src2_fp = 1'b1;
                dec.wr      = 1'b1;
                dec.wr_fp   = 1'b1;
                dec.is_fop  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pst_scoreboard.sv
// Pending-write scoreboard for one register file.
// Two set ports (issue), one clear port (writeback); set wins over clear.
// With ZERO_R0 set, entry 0 is hardwired idle.
module pst_scoreboard #(
    parameter int NREG    = 32,
    parameter bit ZERO_R0 = 1'b0,
    localparam int RW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set0_en,
    input  logic [RW-1:0]   set0_idx,
    input  logic            set1_en,
    input  logic [RW-1:0]   set1_idx,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_idx,
    output logic [NREG-1:0] busy
);

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        localparam logic [RW-1:0] IDX = RW'(i);
        if (ZERO_R0 && i == 0) begin : g_zero
            assign busy[i] = 1'b0;
        end else begin : g_flop
            // Mark on issue, release on writeback.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    busy[i] <= 1'b0;
                else if ((set0_en && set0_idx == IDX) || (set1_en && set1_idx == IDX))
                    busy[i] <= 1'b1;
                else if (clr_en && clr_idx == IDX)
                    busy[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pst_steer.sv
// Issue decision: hazard checks per slot, pairing rules, in-order slot rule
// and packet advance. Assumes fetch holds the packet while advance is low.
module pst_steer
    import pst_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [1:0]      slot_vld,
    input  logic            replay,
    input  dec_t            d_lo,
    input  dec_t            d_hi,
    input  logic [NREG-1:0] int_busy,
    input  logic [NREG-1:0] fp_busy,
    output logic            lo_go,
    output logic            hi_go,
    output logic            advance
);

    function automatic logic stalled(dec_t d, logic [NREG-1:0] ib, logic [NREG-1:0] fb);
        logic s;
        s = 1'b0;
        if (d.use1) s |= d.src1_fp ? fb[d.rs1[RW-1:0]] : ib[d.rs1[RW-1:0]];
        if (d.use2) s |= d.src2_fp ? fb[d.rs2[RW-1:0]] : ib[d.rs2[RW-1:0]];
        if (d.wr)   s |= d.wr_fp   ? fb[d.rd[RW-1:0]]  : ib[d.rd[RW-1:0]];
        return s;
    endfunction

    logic lo_pend, lo_done, shape_ok, load_conf, pair_ok;

    // Slot decisions for the current cycle.
    always_comb begin
        lo_pend   = slot_vld[0] && !replay;
        lo_go     = lo_pend && !stalled(d_lo, int_busy, fp_busy);
        lo_done   = !lo_pend || lo_go;
        shape_ok  = !d_lo.is_fop && d_hi.is_fop;
        load_conf = d_lo.is_fld && (
                      (d_hi.use1 && d_hi.src1_fp && d_hi.rs1[RW-1:0] == d_lo.rd[RW-1:0]) ||
                      (d_hi.use2 && d_hi.src2_fp && d_hi.rs2[RW-1:0] == d_lo.rd[RW-1:0]) ||
                      (d_hi.wr   && d_hi.wr_fp   && d_hi.rd[RW-1:0]  == d_lo.rd[RW-1:0]));
        pair_ok   = !lo_pend || (shape_ok && !load_conf);
        hi_go     = slot_vld[1] && lo_done && pair_ok && !stalled(d_hi, int_busy, fp_busy);
        advance   = lo_done && (!slot_vld[1] || hi_go);
    end

endmodule

// File: rtl/pair_issue_steer.sv
// Top of the dual-issue steering block: decodes both slots, keeps the
// integer and FP scoreboards, remembers an outstanding upper slot and
// routes issued instructions to the integer or FP port by class.
module pair_issue_steer
    import pst_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         slot_vld,
    input  logic [2*INS_W-1:0] pkt,
    input  logic               wb_int_en,
    input  logic [RW-1:0]      wb_int_idx,
    input  logic               wb_fp_en,
    input  logic [RW-1:0]      wb_fp_idx,
    output logic               issue_int,
    output logic [INS_W-1:0]   issue_int_ins,
    output logic               issue_fp,
    output logic [INS_W-1:0]   issue_fp_ins,
    output logic               advance
);

    dec_t            dec [2];
    logic [NREG-1:0] int_busy;
    logic [NREG-1:0] fp_busy;
    logic            replay;
    logic            lo_go, hi_go;
    logic [INS_W-1:0] ins_lo, ins_hi;

    assign ins_lo = pkt[0 +: INS_W];
    assign ins_hi = pkt[INS_W +: INS_W];

    for (genvar s = 0; s < 2; s++) begin : g_dec
        pst_decode u_dec (
            .hdr (pkt[s*INS_W + HDR_LO +: HDR_W]),
            .dec (dec[s])
        );
    end

    pst_steer #(.NREG(NREG)) u_steer (
        .slot_vld (slot_vld),
        .replay   (replay),
        .d_lo     (dec[0]),
        .d_hi     (dec[1]),
        .int_busy (int_busy),
        .fp_busy  (fp_busy),
        .lo_go    (lo_go),
        .hi_go    (hi_go),
        .advance  (advance)
    );

    pst_scoreboard #(.NREG(NREG), .ZERO_R0(1'b1)) u_sb_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .set0_en  (lo_go && dec[0].wr && !dec[0].wr_fp),
        .set0_idx (dec[0].rd[RW-1:0]),
        .set1_en  (hi_go && dec[1].wr && !dec[1].wr_fp),
        .set1_idx (dec[1].rd[RW-1:0]),
        .clr_en   (wb_int_en),
        .clr_idx  (wb_int_idx),
        .busy     (int_busy)
    );

    pst_scoreboard #(.NREG(NREG), .ZERO_R0(1'b0)) u_sb_fp (
        .clk      (clk),
        .rst_n    (rst_n),
        .set0_en  (lo_go && dec[0].wr_fp),
        .set0_idx (dec[0].rd[RW-1:0]),
        .set1_en  (hi_go && dec[1].wr_fp),
        .set1_idx (dec[1].rd[RW-1:0]),
        .clr_en   (wb_fp_en),
        .clr_idx  (wb_fp_idx),
        .busy     (fp_busy)
    );

    // Port routing by class of whichever slot issues.
    always_comb begin
        issue_int     = (lo_go && !dec[0].is_fop) || (hi_go && !dec[1].is_fop);
        issue_fp      = (lo_go && dec[0].is_fop) || (hi_go && dec[1].is_fop);
        issue_int_ins = (lo_go && !dec[0].is_fop) ? ins_lo : ins_hi;
        issue_fp_ins  = (lo_go && dec[0].is_fop) ? ins_lo : ins_hi;
    end

    // Remember that the lower slot of a held packet is already gone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            replay <= 1'b0;
        else if (advance)
            replay <= 1'b0;
        else if (lo_go)
            replay <= 1'b1;
    end

endmodule

// File: rtl/pst_checker.sv
// Property checker for pair_issue_steer, attached with bind.
module pst_checker
    import pst_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       slot_vld,
    input logic             issue_int,
    input logic [INS_W-1:0] issue_int_ins,
    input logic             issue_fp,
    input logic [INS_W-1:0] issue_fp_ins,
    input logic             advance,
    input logic [NREG-1:0]  int_busy,
    input logic [NREG-1:0]  fp_busy
);

    logic int_wr;
    assign int_wr = (issue_int_ins[31:28] == OC_ALU || issue_int_ins[31:28] == OC_LD)
                    && issue_int_ins[23 +: RW] != '0;

    AST_FP_PORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fp |-> issue_fp_ins[31:28] == OC_FOP); // R1
    AST_INT_PORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_int |-> issue_int_ins[31:28] != OC_FOP); // R3
    AST_PAIR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_int && issue_fp) |-> slot_vld == 2'b11); // R2
    AST_FP_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fp |-> !fp_busy[issue_fp_ins[18 +: RW]] && !fp_busy[issue_fp_ins[13 +: RW]]); // R5
    AST_FP_DEST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fp |-> !fp_busy[issue_fp_ins[23 +: RW]]); // R6
    AST_FP_DEST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fp |=> fp_busy[$past(issue_fp_ins[23 +: RW])]); // R7
    AST_INT_DEST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_int && int_wr) |=> int_busy[$past(issue_int_ins[23 +: RW])]); // R7
    AST_ADV_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && slot_vld != 2'b00) |-> (issue_int || issue_fp)); // R9

endmodule

bind pair_issue_steer pst_checker #(.NREG(NREG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_vld      (slot_vld),
    .issue_int     (issue_int),
    .issue_int_ins (issue_int_ins),
    .issue_fp      (issue_fp),
    .issue_fp_ins  (issue_fp_ins),
    .advance       (advance),
    .int_busy      (int_busy),
    .fp_busy       (fp_busy)
);

// File: tb/pair_issue_steer_test.sv
// Self-checking bench: directed corner cases then seeded random packets,
// each cycle compared with a bench model built from the requirements.
module pair_issue_steer_test;

    localparam int NR = 8;
    localparam int RW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      slot_vld = '0;
    logic [63:0]     pkt = '0;
    logic            wb_int_en = 1'b0, wb_fp_en = 1'b0;
    logic [RW-1:0]   wb_int_idx = '0, wb_fp_idx = '0;
    logic            issue_int, issue_fp, advance;
    logic [31:0]     issue_int_ins, issue_fp_ins;

    int checks = 0;
    int errors = 0;
    bit mi [NR];
    bit mf [NR];
    bit mrep;
    bit last_adv;

    always #4 clk = ~clk;

    pair_issue_steer #(.NREG(NR)) uut (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .pkt(pkt),
        .wb_int_en(wb_int_en), .wb_int_idx(wb_int_idx),
        .wb_fp_en(wb_fp_en), .wb_fp_idx(wb_fp_idx),
        .issue_int(issue_int), .issue_int_ins(issue_int_ins),
        .issue_fp(issue_fp), .issue_fp_ins(issue_fp_ins),
        .advance(advance)
    );

    function automatic logic [31:0] mk(int c, int d, int a, int b);
        return {c[3:0], d[4:0], a[4:0], b[4:0], 13'h0};
    endfunction

    function automatic int cls(logic [31:0] x);  return int'(x[31:28]); endfunction
    function automatic int fd(logic [31:0] x);   return int'(x[23 +: RW]); endfunction
    function automatic int fa(logic [31:0] x);   return int'(x[18 +: RW]); endfunction
    function automatic int fb(logic [31:0] x);   return int'(x[13 +: RW]); endfunction
    function automatic bit fop(logic [31:0] x);  return cls(x) == 6; endfunction

    // Any source or destination of x pending in the model.
    function automatic bit blk(logic [31:0] x);
        case (cls(x))
            0:    return mi[fa(x)] || mi[fb(x)] || mi[fd(x)];
            1:    return mi[fa(x)] || mi[fd(x)];
            2, 5: return mi[fa(x)] || mi[fb(x)];
            3:    return mi[fa(x)] || mf[fd(x)];
            4:    return mi[fa(x)] || mf[fb(x)];
            6:    return mf[fa(x)] || mf[fb(x)] || mf[fd(x)];
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Mark the destination of an issued instruction in the model.
    task automatic mark(logic [31:0] x);
        int c = cls(x);
        if ((c == 0 || c == 1) && fd(x) != 0) mi[fd(x)] = 1'b1;
        if (c == 3 || c == 6) mf[fd(x)] = 1'b1;
    endtask

    task automatic step(string tag, logic [1:0] v, logic [31:0] lo, logic [31:0] hi,
                        bit wie, int wi, bit wfe, int wf);
        bit lp, lg, ld, ok, hg, adv, ei, ef;
        logic [31:0] eii, efi;
        @(negedge clk);
        slot_vld = v; pkt = {hi, lo};
        wb_int_en = wie; wb_int_idx = wi[RW-1:0];
        wb_fp_en = wfe;  wb_fp_idx = wf[RW-1:0];
        #2;
        lp  = v[0] && !mrep;
        lg  = lp && !blk(lo);
        ld  = !lp || lg;
        ok  = !lp || (!fop(lo) && fop(hi) &&
                      !(cls(lo) == 3 && (fa(hi) == fd(lo) || fb(hi) == fd(lo) || fd(hi) == fd(lo))));
        hg  = v[1] && ld && ok && !blk(hi);
        adv = ld && (!v[1] || hg);
        ei  = (lg && !fop(lo)) || (hg && !fop(hi));
        ef  = (lg && fop(lo)) || (hg && fop(hi));
        eii = (lg && !fop(lo)) ? lo : hi;
        efi = (lg && fop(lo)) ? lo : hi;
        chk(tag, "issue_int", 32'(issue_int), 32'(ei));
        chk(tag, "issue_fp", 32'(issue_fp), 32'(ef));
        chk(tag, "advance", 32'(advance), 32'(adv));
        if (ei) chk(tag, "int_ins", issue_int_ins, eii);
        if (ef) chk(tag, "fp_ins", issue_fp_ins, efi);
        if (wie) mi[wi] = 1'b0;
        if (wfe) mf[wf] = 1'b0;
        if (lg) mark(lo);
        if (hg) mark(hi);
        if (adv) mrep = 1'b0; else if (lg) mrep = 1'b1;
        last_adv = adv;
    endtask

    function automatic logic [31:0] rnd_ins(bit want_fop);
        int c = want_fop ? 6 : int'($urandom % 6);
        return mk(c, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32));
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0]  rv;
        logic [31:0] rlo, rhi;
        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < NR; i++) begin mi[i] = 0; mf[i] = 0; end
        mrep = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        step("R10", 2'b00, mk(0,1,2,3), mk(6,1,2,3), 0,0, 0,0);
        step("R1",  2'b11, mk(0,1,2,3), mk(6,1,2,3), 0,0, 0,0);
        step("R5",  2'b11, mk(1,4,1,0), mk(6,5,6,7), 1,1, 0,0);
        step("R7",  2'b11, mk(1,4,1,0), mk(6,5,6,7), 0,0, 0,0);
        step("R4",  2'b11, mk(3,2,3,0), mk(6,3,2,6), 0,0, 0,0);
        step("R5",  2'b11, mk(3,2,3,0), mk(6,3,2,6), 0,0, 1,2);
        step("R4",  2'b11, mk(3,2,3,0), mk(6,3,2,6), 0,0, 0,0);
        step("R3",  2'b11, mk(6,0,7,7), mk(0,6,7,7), 0,0, 0,0);
        step("R3",  2'b11, mk(6,0,7,7), mk(0,6,7,7), 0,0, 0,0);
        step("R6",  2'b11, mk(5,0,7,7), mk(6,1,7,7), 0,0, 0,0);
        step("R7",  2'b11, mk(5,0,7,7), mk(6,1,7,7), 0,0, 1,1);
        step("R6",  2'b11, mk(5,0,7,7), mk(6,1,7,7), 0,0, 0,0);
        step("R8",  2'b11, mk(0,0,0,0), mk(6,4,4,4), 0,0, 0,0);
        step("R8",  2'b11, mk(2,0,0,0), mk(6,5,5,5), 0,0, 0,0);
        step("R11", 2'b11, mk(4,0,7,4), mk(6,7,7,7), 0,0, 0,0);
        step("R11", 2'b11, mk(3,0,4,0), mk(6,7,7,7), 0,0, 0,0);
        step("R2",  2'b11, mk(0,7,4,4), mk(6,7,7,7), 1,4, 0,0);
        step("R9",  2'b10, mk(0,0,0,0), mk(6,2,2,2), 0,0, 0,0);
        step("R9",  2'b01, mk(7,0,0,0), mk(6,2,2,2), 0,0, 0,0);
        step("R9",  2'b00, mk(7,0,0,0), mk(6,2,2,2), 0,0, 0,0);

        rv = 2'b11; rlo = mk(7,0,0,0); rhi = mk(6,0,0,0);
        last_adv = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            int wi = int'($urandom % NR);
            int wf = int'($urandom % NR);
            if (last_adv) begin
                int r = int'($urandom % 10);
                rv  = (r < 8) ? 2'b11 : 2'($urandom % 4);
                rlo = rnd_ins(r == 9);
                rhi = rnd_ins(r != 8);
            end
            step("R5", rv, rlo, rhi, mi[wi] && ($urandom % 2 == 0), wi,
                 mf[wf] && ($urandom % 3 != 0), wf);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule